// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Option

A one-direction queue of 36-bit words that crosses between two unrelated clock domains. The producer pushes words on its own clock; the consumer pops them on a second clock that may be unrelated to the first or may be the same clock. Read and write pointers are passed across the boundary in Gray code through a chain of synchroniser flops. Because of this, every flag is raised on time and may be cleared a few cycles late.

A strap input, sampled only while reset is held, selects one of two read behaviours. In standard mode the consumer must issue a read before a word reaches the output register. The read-side flag then means "empty" and the write-side flag means "full". In fall-through mode the head word moves into the output register by itself. The read-side flag then means "output ready" and the write-side flag means "input ready". Two threshold flags report a nearly drained queue and a nearly full queue. Their offset is chosen by a two-bit select, also sampled during reset, from four preset values.

The read side is a small state machine with three states. `RS_STD` is the standard mode, where the output register is loaded only on an accepted read. `RS_DRY` is fall-through mode with no valid word in the output register. `RS_HELD` is fall-through mode with a valid head word on the output. Its transitions are:
- reset to `RS_STD` or `RS_DRY`, according to the strap;
- `RS_DRY` to `RS_HELD` when memory holds a word (load);
- `RS_HELD` to `RS_HELD` on a read while memory holds another word (reload);
- `RS_HELD` to `RS_DRY` on a read while memory is empty (drain).

Top module: `xdom_fifo`

## Requirements
- R1: While `rst_n` is low, both pointers and the output register clear to zero. After reset in standard mode (`fall_thru`=0), `rd_flag`=1, `wr_flag`=0, `almost_empty`=1 and `almost_full`=0. After reset in fall-through mode (`fall_thru`=1), `rd_flag`=0 and `wr_flag`=1.
- R2: `fall_thru` and `ofs_sel` are captured only while `rst_n` is low. Changing them after reset has no effect on behaviour.
- R3: A write while full and a read while empty are both ignored. No word is lost or duplicated, and the output register keeps its value.
- R4: In standard mode a written word stays in memory and `rd_data` does not change until an accepted read. After that read, the word is on `rd_data` at the rising `rd_clk` edge where `rd_en` was sampled high.
- R5: In fall-through mode the head word appears on `rd_data` without a read, and `rd_flag` goes to 1. A read with `rd_flag`=1 consumes that word. The queue holds 2^ADDR_W words in memory plus one in the output register.
- R6: In standard mode `rd_flag` is 1 when empty and `wr_flag` is 1 when full. In fall-through mode `rd_flag` is 1 when a valid word is on the output and `wr_flag` is 1 when a write would be accepted.
- R7: `almost_empty` (read clock) is 1 when the fill level is at or below the offset. In fall-through mode the fill level counts the word in the output register.
- R8: `almost_full` (write clock) is 1 when the free space is at or below the offset. Free space is 2^ADDR_W minus the words held in memory.
- R9: The offset is set by `ofs_sel`: 00 selects OFS_0, 01 selects OFS_1, 10 selects OFS_2 and 11 selects OFS_3. The defaults are 16, 64, 256 and 1024.
- R10: Words leave in the order they were written, under unrelated clocks and with reads and writes in the same cycle. Each pointer crosses the clock boundary in Gray code, changing at most one bit per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides; straps are captured while it is low |
| fall_thru | input | 1 | Mode strap: 0 selects standard, 1 selects fall-through |
| ofs_sel | input | 2 | Threshold offset preset select |
| wr_en | input | 1 | Write request, sampled on `wr_clk` |
| wr_data | input | DATA_W | Word to write |
| wr_flag | output | 1 | Full (standard mode) or input ready (fall-through mode) |
| almost_full | output | 1 | Free space at or below the offset |
| rd_en | input | 1 | Read request, sampled on `rd_clk` |
| rd_data | output | DATA_W | Output register |
| rd_flag | output | 1 | Empty (standard mode) or output ready (fall-through mode) |
| almost_empty | output | 1 | Fill level at or below the offset |

## Verification
The bench builds the block with ADDR_W=5, a 32-word memory, and offsets 2, 4, 8 and 16. With these values both threshold boundaries, the full condition, the extra word held in fall-through mode and many pointer wraps all occur within a few hundred cycles. The write clock runs at a period of 14 ns against 20 ns on the read side, so the Gray-coded pointers cross the boundary at drifting phases. Random traffic in both modes shares a queue model with directed fills and drains.

// File: rtl/xdom_fifo_pkg.sv
package xdom_fifo_pkg;

    typedef enum logic [1:0] {
        RS_STD  = 2'd0,
        RS_DRY  = 2'd1,
        RS_HELD = 2'd2
    } rd_state_e;

    function automatic logic [31:0] pick_ofs(
        input logic [1:0]  sel,
        input logic [31:0] o0,
        input logic [31:0] o1,
        input logic [31:0] o2,
        input logic [31:0] o3
    );
        logic [31:0] r;
        unique case (sel)
            2'b00:   r = o0;
            2'b01:   r = o1;
            2'b10:   r = o2;
            default: r = o3;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/xdom_fifo_sync.sv
module xdom_fifo_sync #(
    parameter int W      = 12,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain[0] <= gray_in;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_g2b
            assign bin_out[g] = ^chain[STAGES-1][W-1:g];
        end
    endgenerate

endmodule

// File: rtl/xdom_fifo_mem.sv
module xdom_fifo_mem #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 36
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];

endmodule

// File: rtl/xdom_fifo_wr.sv
module xdom_fifo_wr
    import xdom_fifo_pkg::*;
#(
    parameter int          ADDR_W = 11,
    parameter logic [31:0] OFS_0  = 32'd16,
    parameter logic [31:0] OFS_1  = 32'd64,
    parameter logic [31:0] OFS_2  = 32'd256,
    parameter logic [31:0] OFS_3  = 32'd1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_thru,
    input  logic [1:0]        ofs_sel,
    input  logic              wr_en,
    input  logic [ADDR_W:0]   rd_ptr_sync,
    output logic [ADDR_W:0]   wr_ptr,
    output logic [ADDR_W:0]   wr_gray,
    output logic              mem_we,
    output logic              wr_flag,
    output logic              almost_full
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic          ft_q;
    logic [1:0]    sel_q;
    logic [PW-1:0] ptr_q, gray_q, ptr_nx, used, free;
    logic          full, accept;
    logic [31:0]   ofs;

    // straps captured only while reset is held
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ft_q  <= fall_thru;
            sel_q <= ofs_sel;
        end
    end

    always_comb begin
        used   = ptr_q - rd_ptr_sync;
        free   = PW'(DEPTH) - used;
        full   = (used == PW'(DEPTH));
        accept = wr_en && !full;
        ptr_nx = ptr_q + PW'(accept);
        ofs    = pick_ofs(sel_q, OFS_0, OFS_1, OFS_2, OFS_3);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            gray_q <= '0;
        end else begin
            ptr_q  <= ptr_nx;
            gray_q <= ptr_nx ^ (ptr_nx >> 1);
        end
    end

    assign wr_ptr      = ptr_q;
    assign wr_gray     = gray_q;
    assign mem_we      = accept;
    assign wr_flag     = ft_q ? !full : full;
    assign almost_full = (32'(free) <= ofs);

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |=> $stable(ptr_q))
        else $error("write accepted while full");

    p_fill_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        used <= PW'(DEPTH))
        else $error("write fill level beyond depth");

    p_gray_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gray_q ^ $past(gray_q)) <= 1)
        else $error("write gray pointer moved more than one bit");

endmodule

// File: rtl/xdom_fifo_rd.sv
module xdom_fifo_rd
    import xdom_fifo_pkg::*;
#(
    parameter int          ADDR_W = 11,
    parameter int          DATA_W = 36,
    parameter logic [31:0] OFS_0  = 32'd16,
    parameter logic [31:0] OFS_1  = 32'd64,
    parameter logic [31:0] OFS_2  = 32'd256,
    parameter logic [31:0] OFS_3  = 32'd1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fall_thru,
    input  logic [1:0]        ofs_sel,
    input  logic              rd_en,
    input  logic [ADDR_W:0]   wr_ptr_sync,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic [ADDR_W:0]   rd_gray,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_flag,
    output logic              almost_empty
);
    localparam int PW = ADDR_W + 1;

    rd_state_e         st_q, st_nx;
    logic [1:0]        sel_q;
    logic [PW-1:0]     ptr_q, gray_q, ptr_nx, mem_cnt, level;
    logic [DATA_W-1:0] dout_q;
    logic              mem_has, load;
    logic [31:0]       ofs;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= ofs_sel;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= fall_thru ? RS_DRY : RS_STD;
        end else begin
            st_q <= st_nx;
        end
    end

    // next state and load decision
    always_comb begin
        mem_cnt = wr_ptr_sync - ptr_q;
        mem_has = (mem_cnt != '0);
        st_nx   = st_q;
        load    = 1'b0;
        unique case (st_q)
            RS_STD: begin
                load = rd_en && mem_has;
            end
            RS_DRY: begin
                if (mem_has) begin
                    load  = 1'b1;
                    st_nx = RS_HELD;
                end
            end
            RS_HELD: begin
                if (rd_en) begin
                    if (mem_has) begin
                        load = 1'b1;
                    end else begin
                        st_nx = RS_DRY;
                    end
                end
            end
            default: begin
                st_nx = RS_STD;
            end
        endcase
        ptr_nx = ptr_q + PW'(load);
    end

    // datapath and flag outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            gray_q <= '0;
            dout_q <= '0;
        end else begin
            ptr_q  <= ptr_nx;
            gray_q <= ptr_nx ^ (ptr_nx >> 1);
            if (load) begin
                dout_q <= mem_rdata;
            end
        end
    end

    always_comb begin
        ofs          = pick_ofs(sel_q, OFS_0, OFS_1, OFS_2, OFS_3);
        level        = mem_cnt + PW'(st_q == RS_HELD);
        rd_flag      = (st_q == RS_STD) ? !mem_has : (st_q == RS_HELD);
        almost_empty = (32'(level) <= ofs);
    end

    assign mem_raddr = ptr_q[ADDR_W-1:0];
    assign rd_gray   = gray_q;
    assign rd_data   = dout_q;

    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RS_STD && rd_en && rd_flag) |=> ($stable(ptr_q) && $stable(dout_q)))
        else $error("read accepted while empty");

    p_std_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RS_STD && !rd_en) |=> $stable(dout_q))
        else $error("standard output changed without read");

    p_ft_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RS_HELD && !rd_en) |=> ($stable(dout_q) && rd_flag))
        else $error("held head word lost without read");

    p_ft_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == RS_DRY && mem_has) |=> rd_flag)
        else $error("head word did not fall through");

    p_gray_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gray_q ^ $past(gray_q)) <= 1)
        else $error("read gray pointer moved more than one bit");

endmodule

// File: rtl/xdom_fifo.sv
module xdom_fifo #(
    parameter int          DATA_W      = 36,
    parameter int          ADDR_W      = 11,
    parameter int          SYNC_STAGES = 2,
    parameter logic [31:0] OFS_0       = 32'd16,
    parameter logic [31:0] OFS_1       = 32'd64,
    parameter logic [31:0] OFS_2       = 32'd256,
    parameter logic [31:0] OFS_3       = 32'd1024
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              fall_thru,
    input  logic [1:0]        ofs_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_flag,
    output logic              almost_full,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_flag,
    output logic              almost_empty
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0]     wr_ptr, wr_gray, rd_gray, wr_ptr_rd, rd_ptr_wr;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_raddr;
    logic [DATA_W-1:0] mem_rdata;

    xdom_fifo_wr #(
        .ADDR_W(ADDR_W), .OFS_0(OFS_0), .OFS_1(OFS_1), .OFS_2(OFS_2), .OFS_3(OFS_3)
    ) u_wr (
        .clk(wr_clk), .rst_n(rst_n), .fall_thru(fall_thru), .ofs_sel(ofs_sel),
        .wr_en(wr_en), .rd_ptr_sync(rd_ptr_wr), .wr_ptr(wr_ptr), .wr_gray(wr_gray),
        .mem_we(mem_we), .wr_flag(wr_flag), .almost_full(almost_full)
    );

    xdom_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk(rd_clk), .rst_n(rst_n), .gray_in(wr_gray), .bin_out(wr_ptr_rd)
    );

    xdom_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk(wr_clk), .rst_n(rst_n), .gray_in(rd_gray), .bin_out(rd_ptr_wr)
    );

    xdom_fifo_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .wclk(wr_clk), .we(mem_we), .waddr(wr_ptr[ADDR_W-1:0]), .wdata(wr_data),
        .raddr(mem_raddr), .rdata(mem_rdata)
    );

    xdom_fifo_rd #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .OFS_0(OFS_0), .OFS_1(OFS_1), .OFS_2(OFS_2), .OFS_3(OFS_3)
    ) u_rd (
        .clk(rd_clk), .rst_n(rst_n), .fall_thru(fall_thru), .ofs_sel(ofs_sel),
        .rd_en(rd_en), .wr_ptr_sync(wr_ptr_rd), .mem_rdata(mem_rdata),
        .mem_raddr(mem_raddr), .rd_gray(rd_gray), .rd_data(rd_data),
        .rd_flag(rd_flag), .almost_empty(almost_empty)
    );

endmodule

// File: tb/xdom_fifo_tb.sv
module xdom_fifo_tb;
    localparam int AW    = 5;
    localparam int DEPTH = 1 << AW;
    localparam int DW    = 36;

    logic          wclk = 1'b0;
    logic          rclk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fall_thru = 1'b0;
    logic [1:0]    ofs_sel = 2'b00;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic          wr_flag, almost_full, rd_flag, almost_empty;
    logic [DW-1:0] rd_data;

    always #10 rclk = ~rclk;
    always #7  wclk = ~wclk;

    xdom_fifo #(
        .DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2),
        .OFS_0(32'd2), .OFS_1(32'd4), .OFS_2(32'd8), .OFS_3(32'd16)
    ) u_dut (
        .wr_clk(wclk), .rd_clk(rclk), .rst_n(rst_n), .fall_thru(fall_thru),
        .ofs_sel(ofs_sel), .wr_en(wr_en), .wr_data(wr_data), .wr_flag(wr_flag),
        .almost_full(almost_full), .rd_en(rd_en), .rd_data(rd_data),
        .rd_flag(rd_flag), .almost_empty(almost_empty)
    );

    int            errors = 0;
    int            checks = 0;
    bit            done = 0;
    bit            cur_ft = 0;
    logic [DW-1:0] q[$];

    function automatic int exp_ofs(input logic [1:0] s);  // R9 encoding
        case (s)
            2'b00:   return 2;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 16;
        endcase
    endfunction

    function automatic bit is_full();
        return cur_ft ? !wr_flag : wr_flag;
    endfunction

    function automatic logic [DW-1:0] rnd_word();
        return {4'($urandom), $urandom};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rst_dut(input bit ft, input logic [1:0] sel);
        rst_n = 1'b0;
        fall_thru = ft;
        ofs_sel = sel;
        wr_en = 1'b0;
        rd_en = 1'b0;
        q.delete();
        cur_ft = ft;
        repeat (3) @(negedge rclk);
        rst_n = 1'b1;
        repeat (2) @(negedge rclk);
    endtask

    task automatic settle();
        repeat (6) @(negedge rclk);
        repeat (6) @(negedge wclk);
    endtask

    task automatic wr_one(input logic [DW-1:0] d);
        @(negedge wclk);
        if (!is_full()) q.push_back(d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge wclk);
        wr_en = 1'b0;
    endtask

    task automatic fill_to(input int n);
        while (q.size() < n) wr_one(rnd_word());
        settle();
    endtask

    task automatic drain_std();
        for (int i = 0; i < 3 * DEPTH; i++) begin
            @(negedge rclk);
            if (!rd_flag) begin
                logic [DW-1:0] e;
                e = q.pop_front();
                rd_en = 1'b1;
                @(negedge rclk);
                rd_en = 1'b0;
                chk(rd_data == e, "R10 standard drain order", rd_data, e);
            end
        end
        settle();
        chk(q.size() == 0, "R10 standard drain count", q.size(), 0);
        chk(rd_flag == 1'b1, "R6 empty after drain", rd_flag, 1);
    endtask

    task automatic drain_ft();
        for (int i = 0; i < 3 * DEPTH; i++) begin
            @(negedge rclk);
            if (rd_flag) begin
                chk(q.size() > 0 && rd_data == q[0], "R10 fall-through drain order", rd_data, q[0]);
                void'(q.pop_front());
                rd_en = 1'b1;
            end else begin
                rd_en = 1'b0;
            end
        end
        rd_en = 1'b0;
        settle();
        chk(q.size() == 0, "R10 fall-through drain count", q.size(), 0);
        chk(rd_flag == 1'b0, "R6 output not ready after drain", rd_flag, 0);
    endtask

    task automatic rand_run(input bit ft);
        rst_dut(ft, 2'b10);
        fork
            begin
                for (int i = 0; i < 700; i++) begin
                    @(negedge wclk);
                    if (($urandom % 100) < 55 && !is_full()) begin
                        logic [DW-1:0] d;
                        d = rnd_word();
                        q.push_back(d);
                        wr_en = 1'b1;
                        wr_data = d;
                    end else begin
                        wr_en = 1'b0;
                    end
                end
                @(negedge wclk);
                wr_en = 1'b0;
            end
            begin
                bit            pend = 0;
                logic [DW-1:0] e = '0;
                for (int i = 0; i < 1400; i++) begin
                    @(negedge rclk);
                    if (ft) begin
                        if (rd_flag && ($urandom % 100) < 50) begin
                            chk(q.size() > 0 && rd_data == q[0], "R10 random fall-through order", rd_data, q[0]);
                            void'(q.pop_front());
                            rd_en = 1'b1;
                        end else begin
                            rd_en = 1'b0;
                        end
                    end else begin
                        if (pend) begin
                            chk(rd_data == e, "R10 random standard order", rd_data, e);
                            pend = 0;
                        end
                        if (!rd_flag && ($urandom % 100) < 50) begin
                            e = q.pop_front();
                            pend = 1;
                            rd_en = 1'b1;
                        end else begin
                            rd_en = 1'b0;
                        end
                    end
                end
                @(negedge rclk);
                if (pend) chk(rd_data == e, "R10 random standard order", rd_data, e);
                rd_en = 1'b0;
            end
        join
        settle();
        chk(q.size() == 0, "R10 random run fully drained", q.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge rclk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] a;
        void'($urandom(32'd4242));

        // standard mode, offset select 01 -> 4
        rst_dut(1'b0, 2'b01);
        chk(rd_flag == 1'b1, "R1 std empty after reset", rd_flag, 1);
        chk(wr_flag == 1'b0, "R1 std not full after reset", wr_flag, 0);
        chk(almost_empty == 1'b1, "R1 almost_empty after reset", almost_empty, 1);
        chk(almost_full == 1'b0, "R1 almost_full after reset", almost_full, 0);
        chk(rd_data == '0, "R1 output cleared", rd_data, 0);

        @(negedge rclk); rd_en = 1'b1;
        @(negedge rclk); rd_en = 1'b0;
        chk(rd_data == '0, "R3 read while empty keeps output", rd_data, 0);
        chk(rd_flag == 1'b1, "R3 read while empty stays empty", rd_flag, 1);

        a = rnd_word();
        wr_one(a);
        settle();
        chk(rd_flag == 1'b0, "R6 std empty clears", rd_flag, 0);
        chk(rd_data == '0, "R4 word stays in memory before read", rd_data, 0);
        @(negedge rclk); rd_en = 1'b1;
        @(negedge rclk); rd_en = 1'b0;
        chk(rd_data == a, "R4 word on output after read", rd_data, a);
        void'(q.pop_front());
        settle();
        chk(rd_flag == 1'b1, "R6 std empty again", rd_flag, 1);

        fill_to(exp_ofs(2'b01));
        chk(almost_empty == 1'b1, "R7 level at offset", almost_empty, 1);
        fill_to(exp_ofs(2'b01) + 1);
        chk(almost_empty == 1'b0, "R7 level above offset", almost_empty, 0);
        fill_to(DEPTH - exp_ofs(2'b01) - 1);
        chk(almost_full == 1'b0, "R8 free above offset", almost_full, 0);
        fill_to(DEPTH - exp_ofs(2'b01));
        chk(almost_full == 1'b1, "R8 free at offset", almost_full, 1);
        for (int i = 0; i < 12; i++) wr_one(rnd_word());
        settle();
        chk(q.size() == DEPTH, "R3 writes while full dropped", q.size(), DEPTH);
        chk(wr_flag == 1'b1, "R6 std full flag", wr_flag, 1);
        drain_std();

        // straps changed after reset must not matter
        rst_dut(1'b0, 2'b11);
        ofs_sel = 2'b00;
        fall_thru = 1'b1;
        fill_to(exp_ofs(2'b11));
        chk(almost_empty == 1'b1, "R2 R9 offset 11 kept at 16", almost_empty, 1);
        chk(rd_data == '0, "R2 mode strap ignored after reset", rd_data, 0);
        fill_to(exp_ofs(2'b11) + 1);
        chk(almost_empty == 1'b0, "R9 level above offset 16", almost_empty, 0);
        drain_std();

        // fall-through mode
        rst_dut(1'b1, 2'b01);
        chk(rd_flag == 1'b0, "R1 ft output not ready after reset", rd_flag, 0);
        chk(wr_flag == 1'b1, "R1 ft input ready after reset", wr_flag, 1);
        a = rnd_word();
        wr_one(a);
        settle();
        chk(rd_flag == 1'b1, "R5 head ready without read", rd_flag, 1);
        chk(rd_data == a, "R5 head word on output", rd_data, a);
        fill_to(exp_ofs(2'b01));
        chk(almost_empty == 1'b1, "R7 ft level counts output word", almost_empty, 1);
        fill_to(exp_ofs(2'b01) + 1);
        chk(almost_empty == 1'b0, "R7 ft level above offset", almost_empty, 0);
        for (int i = 0; i < 45; i++) wr_one(rnd_word());
        settle();
        chk(q.size() == DEPTH + 1, "R5 capacity with output stage", q.size(), DEPTH + 1);
        chk(wr_flag == 1'b0, "R6 ft input not ready when full", wr_flag, 0);
        chk(almost_full == 1'b1, "R8 ft memory full", almost_full, 1);
        drain_ft();

        rand_run(1'b1);
        rand_run(1'b0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule